// File: doc/BRIEF.md
# Taint-Tagged Operand Access Unit

This block keeps a small register file and a program counter in which every stored word carries a one-bit secrecy tag. A word with the tag set is "blinded": its value must not steer control flow. An execution pipeline uses the block to resolve a source operand into a tagged value without waiting for a clock edge. It also applies destination writes, one per clock edge, following a fixed set of safety rules.

An operand names the program counter, a register selected by index, or an immediate value carried in the request. Out-of-range register reads return a clear zero and out-of-range register writes are dropped. The program counter never holds a blinded value or an address outside the memory. A PC write that would break either rule leaves the PC at zero instead.

Top module: `tagged_opnd_unit`

## Requirements
- R1: The operand kind is a 2-bit code: 2'b00 selects the program counter, 2'b01 selects a register by index, and 2'b10 selects an immediate. Code 2'b11 behaves exactly like an immediate.
- R2: Reading the PC returns its value and reading an immediate returns the supplied immediate. In both cases the tag is clear and the result appears in the same cycle as the request.
- R3: Reading a register index equal to or above NUM_REGS returns value zero with the tag clear.
- R4: A PC write whose tag is set leaves the PC at zero after the clock edge.
- R5: A PC write with a clear tag takes the written value when that value is below MEM_SIZE. When the value is MEM_SIZE or more, the PC becomes zero.
- R6: A register write to an index at or above NUM_REGS changes no state. A write with an immediate kind (2'b10 or 2'b11) also changes no state.
- R7: A register write stores both the value and the tag. A read of that index after the edge returns exactly the pair that was written, and other registers keep their contents.
- R8: Writes take effect one per rising edge in the order presented. A later write to the same target overrides an earlier one.
- R9: An active-low reset clears every register, every tag and the PC to zero.
- R10: While wr_en is low, no state changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_kind | input | 2 | Source operand kind |
| rd_idx | input | IDX_W | Source register index |
| rd_imm | input | WORD_W | Source immediate value |
| rd_val | output | WORD_W | Resolved source value |
| rd_tag | output | 1 | Resolved source secrecy tag |
| wr_en | input | 1 | Destination write enable |
| wr_kind | input | 2 | Destination operand kind |
| wr_idx | input | IDX_W | Destination register index |
| wr_val | input | WORD_W | Value to write |
| wr_tag | input | 1 | Secrecy tag of the value to write |
| pc | output | WORD_W | Current program counter |

## Verification
Source reads are combinational, so rd_val and rd_tag are due in the same cycle their request is applied. A write lands on the first rising edge after it is presented, so it becomes visible on pc and on a read one edge later. The bench drives every write at a falling edge and removes it at the next falling edge. Only then does it set up the read and sample, shortly after that falling edge. Back-to-back writes are held for exactly one edge each, so the final read shows which of them won.

// File: rtl/tagged_opnd_unit.sv
module tagged_opnd_unit #(
  parameter int NUM_REGS = 12,
  parameter int IDX_W    = 4,
  parameter int WORD_W   = 16,
  parameter int MEM_SIZE = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rd_kind,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_imm,
  output logic [WORD_W-1:0] rd_val,
  output logic              rd_tag,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_val,
  input  logic              wr_tag,
  output logic [WORD_W-1:0] pc
);
  localparam logic [1:0]      K_PC    = 2'b00;
  localparam logic [1:0]      K_REG   = 2'b01;
  localparam logic [IDX_W:0]  REG_LIM = (IDX_W+1)'(NUM_REGS);
  localparam logic [WORD_W:0] MEM_LIM = (WORD_W+1)'(MEM_SIZE);

  logic [WORD_W-1:0] rf_val [NUM_REGS];
  logic              rf_tag [NUM_REGS];
  logic [WORD_W-1:0] pc_q;

  wire rd_in  = {1'b0, rd_idx} < REG_LIM;
  wire wr_in  = {1'b0, wr_idx} < REG_LIM;
  wire pc_ok  = !wr_tag && ({1'b0, wr_val} < MEM_LIM);

  assign pc = pc_q;

  always_comb begin
    rd_val = rd_imm;
    rd_tag = 1'b0;
    case (rd_kind)
      K_PC:  rd_val = pc_q;
      K_REG: begin
        rd_val = rd_in ? rf_val[rd_idx] : '0;
        rd_tag = rd_in ? rf_tag[rd_idx] : 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      for (int i = 0; i < NUM_REGS; i++) begin
        rf_val[i] <= '0;
        rf_tag[i] <= 1'b0;
      end
    end else if (wr_en) begin
      case (wr_kind)
        K_PC:  pc_q <= pc_ok ? wr_val : '0;
        K_REG: if (wr_in) begin
          rf_val[wr_idx] <= wr_val;
          rf_tag[wr_idx] <= wr_tag;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tagged_opnd_unit_chk.sv
module tagged_opnd_unit_chk #(
  parameter int NUM_REGS = 12,
  parameter int IDX_W    = 4,
  parameter int WORD_W   = 16,
  parameter int MEM_SIZE = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rd_kind,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [WORD_W-1:0] rd_imm,
  input logic [WORD_W-1:0] rd_val,
  input logic              rd_tag,
  input logic              wr_en,
  input logic [1:0]        wr_kind,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [WORD_W-1:0] wr_val,
  input logic              wr_tag,
  input logic [WORD_W-1:0] pc
);
  localparam logic [IDX_W:0]  REG_LIM = (IDX_W+1)'(NUM_REGS);
  localparam logic [WORD_W:0] MEM_LIM = (WORD_W+1)'(MEM_SIZE);

  p_imm_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kind[1] |-> (rd_val == rd_imm && !rd_tag));

  p_pc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_kind == 2'b00 |-> (rd_val == pc && !rd_tag));

  p_oob_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kind == 2'b01 && {1'b0, rd_idx} >= REG_LIM) |-> (rd_val == '0 && !rd_tag));

  p_pc_blind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b00 && wr_tag) |=> pc == '0);

  p_pc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pc} < MEM_LIM);

  p_imm_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind[1]) |=> $stable(pc));

  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b01 && {1'b0, wr_idx} < REG_LIM
     && rd_kind == 2'b01 && rd_idx == wr_idx)
    |=> (!($stable(rd_kind) && $stable(rd_idx))
         || (rd_val == $past(wr_val) && rd_tag == $past(wr_tag))));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pc));
endmodule

bind tagged_opnd_unit tagged_opnd_unit_chk #(
  .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .WORD_W(WORD_W), .MEM_SIZE(MEM_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_imm(rd_imm),
  .rd_val(rd_val), .rd_tag(rd_tag), .wr_en(wr_en), .wr_kind(wr_kind),
  .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag), .pc(pc)
);

// File: tb/tagged_opnd_unit_tb.sv
module tagged_opnd_unit_tb;
  localparam int NR = 12, IW = 4, WW = 16, MS = 1000;

  typedef struct packed {
    logic        we;
    logic [1:0]  wk;
    logic [3:0]  wi;
    logic [15:0] wv;
    logic        wt;
    logic [1:0]  rk;
    logic [3:0]  ri;
    logic [15:0] rimm;
    logic [15:0] ev;
    logic        et;
    logic [15:0] epc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 4'd3,  16'h1234, 1'b1, 2'd1, 4'd3,  16'h0, 16'h1234, 1'b1, 16'd0,   4'd7},
    '{1'b1, 2'd1, 4'd3,  16'h00AA, 1'b0, 2'd1, 4'd3,  16'h0, 16'h00AA, 1'b0, 16'd0,   4'd8},
    '{1'b1, 2'd1, 4'd12, 16'hFFFF, 1'b1, 2'd1, 4'd12, 16'h0, 16'h0000, 1'b0, 16'd0,   4'd3},
    '{1'b0, 2'd0, 4'd0,  16'h0,    1'b0, 2'd1, 4'd11, 16'h0, 16'h0000, 1'b0, 16'd0,   4'd6},
    '{1'b1, 2'd0, 4'd0,  16'd500,  1'b0, 2'd0, 4'd0,  16'h0, 16'd500,  1'b0, 16'd500, 4'd5},
    '{1'b1, 2'd0, 4'd0,  16'd999,  1'b0, 2'd0, 4'd0,  16'h0, 16'd999,  1'b0, 16'd999, 4'd5},
    '{1'b1, 2'd0, 4'd0,  16'd1000, 1'b0, 2'd0, 4'd0,  16'h0, 16'd0,    1'b0, 16'd0,   4'd5},
    '{1'b1, 2'd0, 4'd0,  16'd300,  1'b0, 2'd0, 4'd0,  16'h0, 16'd300,  1'b0, 16'd300, 4'd5},
    '{1'b1, 2'd0, 4'd0,  16'd42,   1'b1, 2'd0, 4'd0,  16'h0, 16'd0,    1'b0, 16'd0,   4'd4},
    '{1'b1, 2'd0, 4'd0,  16'd77,   1'b0, 2'd0, 4'd0,  16'h0, 16'd77,   1'b0, 16'd77,  4'd5},
    '{1'b1, 2'd2, 4'd0,  16'd5,    1'b0, 2'd0, 4'd0,  16'h0, 16'd77,   1'b0, 16'd77,  4'd6},
    '{1'b1, 2'd3, 4'd3,  16'd9,    1'b1, 2'd3, 4'd0,  16'h1357, 16'h1357, 1'b0, 16'd77, 4'd1},
    '{1'b0, 2'd0, 4'd0,  16'd12,   1'b0, 2'd1, 4'd3,  16'h0, 16'h00AA, 1'b0, 16'd77,  4'd10},
    '{1'b0, 2'd1, 4'd3,  16'h5555, 1'b1, 2'd2, 4'd0,  16'hBEEF, 16'hBEEF, 1'b0, 16'd77, 4'd2},
    '{1'b1, 2'd1, 4'd0,  16'h0F0F, 1'b1, 2'd1, 4'd3,  16'h0, 16'h00AA, 1'b0, 16'd77,  4'd7},
    '{1'b0, 2'd0, 4'd0,  16'h0,    1'b0, 2'd1, 4'd0,  16'h0, 16'h0F0F, 1'b1, 16'd77,  4'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rd_kind = '0, wr_kind = '0;
  logic [IW-1:0] rd_idx = '0, wr_idx = '0;
  logic [WW-1:0] rd_imm = '0, wr_val = '0, rd_val, pc;
  logic rd_tag, wr_en = 1'b0, wr_tag = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tagged_opnd_unit #(.NUM_REGS(NR), .IDX_W(IW), .WORD_W(WW), .MEM_SIZE(MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_imm(rd_imm),
    .rd_val(rd_val), .rd_tag(rd_tag), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag), .pc(pc));

  task automatic check(input string rq, input logic [WW-1:0] av, ev,
                       input logic at, et, input logic [WW-1:0] ap, ep);
    n_chk++;
    if (av !== ev || at !== et || ap !== ep) begin
      n_bad++;
      $display("FAIL %s: val=%h tag=%b pc=%0d expected val=%h tag=%b pc=%0d",
               rq, av, at, ap, ev, et, ep);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [IW-1:0] i,
                    input logic [WW-1:0] v, input logic t);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_val = v; wr_tag = t;
  endtask

  task automatic rd_chk(input string rq, input logic [1:0] k, input logic [IW-1:0] i,
                        input logic [WW-1:0] ev, input logic et, input logic [WW-1:0] ep);
    @(negedge clk);
    wr_en = 1'b0;
    rd_kind = k; rd_idx = i; rd_imm = '0;
    #1 check(rq, rd_val, ev, rd_tag, et, pc, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_kind = 2'b01; rd_idx = 4'd3;
    #1 check("R9 reset", rd_val, '0, rd_tag, 1'b0, pc, '0);
    rst_n = 1'b1;
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      wr_en = VEC[n].we; wr_kind = VEC[n].wk; wr_idx = VEC[n].wi;
      wr_val = VEC[n].wv; wr_tag = VEC[n].wt;
      @(negedge clk);
      wr_en = 1'b0;
      rd_kind = VEC[n].rk; rd_idx = VEC[n].ri; rd_imm = VEC[n].rimm;
      #1 check($sformatf("R%0d vec%0d", VEC[n].req, n),
               rd_val, VEC[n].ev, rd_tag, VEC[n].et, pc, VEC[n].epc);
    end
    // R8: three back-to-back writes, last wins
    wr(2'b01, 4'd5, 16'h0001, 1'b1);
    wr(2'b01, 4'd5, 16'h0002, 1'b0);
    wr(2'b01, 4'd5, 16'h0003, 1'b1);
    rd_chk("R8 back-to-back reg", 2'b01, 4'd5, 16'h0003, 1'b1, 16'd77);
    wr(2'b00, 4'd0, 16'd10, 1'b0);
    wr(2'b00, 4'd0, 16'd20, 1'b0);
    rd_chk("R8 back-to-back pc", 2'b00, 4'd0, 16'd20, 1'b0, 16'd20);
    // R5 blinded in-range then clear out-of-range back to back
    wr(2'b00, 4'd0, 16'd5, 1'b1);
    wr(2'b00, 4'd0, 16'hFFFF, 1'b0);
    rd_chk("R5 max value", 2'b00, 4'd0, 16'd0, 1'b0, 16'd0);
    // R9: mid-run reset clears stored state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R9 mid reset reg0", 2'b01, 4'd0, 16'h0, 1'b0, 16'd0);
    rd_chk("R9 mid reset reg5", 2'b01, 4'd5, 16'h0, 1'b0, 16'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule